// File: doc/BRIEF.md
# Infrared Carrier-Modulated Transmitter

This block turns queued bytes into timed bit cells on a single LED drive output. A byte write port fills a 16-entry transmit queue. A small state machine takes bytes from the head of the queue and plays them out one bit cell at a time. The length of a cell comes from a 16-bit divisor that is supplied as two byte-wide halves. A cell at level 0 fires a short burst of carrier pulses on the LED. A cell at level 1 keeps the LED dark. The carrier generator restarts at the start of every cell. Its period, its high time and the number of pulses in a burst are set by control inputs.

Bytes are read in one of two ways. In plain mode each byte gives eight cells, starting with bit 0. In run-length mode a byte gives one level and a repeat count. The mode is taken from `rle_mode` at the moment each byte leaves the queue. When the deferral input is set, the block holds its start until enough bytes are queued, so that a frame is not cut short by an empty queue. When deferral is off, the block starts on the first byte, and a frame that runs the queue dry is flagged as an underrun.

The controller has three states. In IDLE the output is dark. IDLE moves to LOAD once the start condition holds: a queue level of at least `DEFER_LVL` with deferral on, or at least one byte with deferral off. LOAD pops the head byte and always moves to CELL. CELL counts out the current cell. At the last clock of a byte's last cell, CELL stays in CELL and pops the next byte if the queue has one. If the queue is empty it returns to IDLE.

Top module: `ir_mod_tx`

## Requirements
- R1: In plain mode (`rle_mode`=0) each byte produces 8 cells, and the level of cell i is bit i of the byte. The first cell is bit 0.
- R2: Every cell lasts D+1 clock cycles, where D = {`div_hi`,`div_lo`} (`div_hi` is the upper byte).
- R3: During a cell at level 1, `led_o` stays 0. During a cell at level 0, `led_o` is 1 exactly in the clocks at offset k inside the cell (k counted from 0) for which k/P < N and k mod P < H.
- R4: The carrier period P in clocks is 8 + `carrier_code` when `carrier_hi_range`=1, and 32 + 4·`carrier_code` when `carrier_hi_range`=0.
- R5: The burst holds N = `pulse_sel`+1 pulses. The high time is H = floor(P·E/8), where E = `duty_sel`+1 for `duty_sel` ≤ 3 and E = 4 for any larger value.
- R6: In run-length mode (`rle_mode`=1 when the byte leaves the queue), bit 7 gives the level, and bits 6:0 plus one give the number of cells sent at that level.
- R7: With `defer_en`=1, no transmission starts while fewer than `DEFER_LVL` bytes (default 4) are queued. Once the level is reached, the queued bytes are sent back to back.
- R8: The queue holds 16 bytes, and a write made while it is full is dropped. `fifo_empty_o` and `fifo_full_o` report the queue level and are never high together.
- R9: `underrun_o` is set when a transmission ends on an empty queue while `defer_en`=0. It is cleared when the next transmission starts, and it never rises while `defer_en`=1.
- R10: After reset `led_o`, `busy_o` and `underrun_o` are 0 and the queue is empty. `busy_o` is high for 1 + (cells sent)·(D+1) cycles per transmission, and `led_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| div_lo | input | 8 | Low byte of the cell divisor |
| div_hi | input | 8 | High byte of the cell divisor |
| carrier_hi_range | input | 1 | 1 selects the high-speed carrier range |
| carrier_code | input | 5 | Carrier frequency code within the range |
| pulse_sel | input | 2 | Pulses per burst minus one |
| duty_sel | input | 3 | Carrier high time in eighths minus one (clamped at 4/8) |
| rle_mode | input | 1 | 1 reads queued bytes as run-length codes |
| defer_en | input | 1 | 1 holds the start until the queue reaches the deferral level |
| led_o | output | 1 | LED drive, 1 = lit |
| busy_o | output | 1 | Transmission in progress |
| fifo_empty_o | output | 1 | Transmit queue is empty |
| fifo_full_o | output | 1 | Transmit queue is full |
| underrun_o | output | 1 | Last transmission ran the queue dry without deferral |

## Verification
The checker watches several rules on every cycle:
- the LED stays dark outside a transmission;
- the LED stays dark after any cycle spent in a level-1 cell;
- the empty and full flags are never high together;
- a full queue stays full until a byte is popped;
- IDLE does not leave while deferral is on and the queue is below its level;
- underrun never rises with deferral on.

Other properties only show up in the bench's scenarios, where the LED waveform is compared clock by clock with a model computed from the cell, carrier, pulse-count and duty formulas. These are bit order, cell length, the exact shape of the pulse train, the run-length expansion, and the loss of bytes written into a full queue.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CELL = 2'd2
    } tx_state_e;

    localparam int BYTE_W     = 8;
    localparam int BYTE_CELLS = 8;
    localparam int CODE_W     = 5;
    localparam int PER_W      = 8;

    // Carrier period in system clocks for a range and code.
    function automatic logic [PER_W-1:0] carrier_period(input logic hi_range,
                                                        input logic [CODE_W-1:0] code);
        logic [PER_W-1:0] p;
        if (hi_range)
            p = 8'd8 + {3'b000, code};
        else
            p = 8'd32 + {1'b0, code, 2'b00};
        return p;
    endfunction

    // High time of one carrier pulse: period * eighths / 8, eighths clamped to 4.
    function automatic logic [PER_W-1:0] carrier_high(input logic [PER_W-1:0] per,
                                                      input logic [2:0] duty);
        logic [2:0]  eighths;
        logic [10:0] prod;
        eighths = (duty > 3'd3) ? 3'd4 : duty + 3'd1;
        prod    = {3'b000, per} * {8'd0, eighths};
        return prod[10:3];
    endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2 = (DEPTH == (1 << AW));

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp, wp_nx, rp_nx;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if (POW2) begin : g_wrap_nat
            assign wp_nx = wp + AW'(1);
            assign rp_nx = rp + AW'(1);
        end else begin : g_wrap_cmp
            assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp_nx;
            if (pop_ok)  rp <= rp_nx;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen import ir_tx_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              hi_range,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        pulse_sel,
    input  logic [2:0]        duty_sel,
    output logic              carrier_on
);
    logic [PER_W-1:0] per, high_t;
    logic [PER_W-1:0] ph;
    logic [2:0]       pulse_idx, pulse_lim;

    always_comb begin
        per       = carrier_period(hi_range, code);
        high_t    = carrier_high(per, duty_sel);
        pulse_lim = {1'b0, pulse_sel} + 3'd1;
    end

    // Phase counter and pulse index; restart makes the next cycle offset zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph        <= '0;
            pulse_idx <= '0;
        end else if (restart) begin
            ph        <= '0;
            pulse_idx <= '0;
        end else if (ph >= per - PER_W'(1)) begin
            ph <= '0;
            if (pulse_idx != 3'd7)
                pulse_idx <= pulse_idx + 3'd1;
        end else begin
            ph <= ph + PER_W'(1);
        end
    end

    assign carrier_on = (ph < high_t) && (pulse_idx < pulse_lim);
endmodule

// File: rtl/ir_tx_ctrl.sv
module ir_tx_ctrl import ir_tx_pkg::*; #(
    parameter int CW        = 5,
    parameter int DEFER_LVL = 4,
    parameter int DIV_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             defer_en,
    input  logic             rle_mode,
    input  logic [DIV_W-1:0] cell_div,
    input  logic [CW-1:0]    fifo_count,
    input  logic             fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    input  logic             carrier_on,
    output logic             fifo_pop,
    output logic             car_restart,
    output logic             led_o,
    output logic             busy_o,
    output logic             underrun_o,
    output tx_state_e        state_o,
    output logic             cur_level_o
);
    tx_state_e         st, st_nx;
    logic [DIV_W-1:0]  tmr;
    logic [7:0]        cells_left;
    logic [BYTE_W-1:0] byte_q;
    logic              rle_q;
    logic              start_ok, cell_end, byte_end, cur_level;

    assign start_ok  = defer_en ? (fifo_count >= CW'(DEFER_LVL)) : !fifo_empty;
    assign cell_end  = (st == ST_CELL) && (tmr == cell_div);
    assign byte_end  = cell_end && (cells_left == 8'd1);
    assign cur_level = rle_q ? byte_q[BYTE_W-1] : byte_q[0];

    assign fifo_pop    = (st == ST_LOAD) || (byte_end && !fifo_empty);
    assign car_restart = (st == ST_LOAD) || cell_end;
    assign state_o     = st;
    assign cur_level_o = cur_level;

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start_ok) st_nx = ST_LOAD;
            ST_LOAD: st_nx = ST_CELL;
            ST_CELL: if (byte_end && fifo_empty) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Cell timer, cell counter and current byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr        <= '0;
            cells_left <= '0;
            byte_q     <= '1;
            rle_q      <= 1'b0;
        end else if (fifo_pop) begin
            tmr        <= '0;
            byte_q     <= fifo_head;
            rle_q      <= rle_mode;
            cells_left <= rle_mode ? ({1'b0, fifo_head[6:0]} + 8'd1) : 8'(BYTE_CELLS);
        end else if (cell_end) begin
            tmr        <= '0;
            cells_left <= cells_left - 8'd1;
            if (!rle_q)
                byte_q <= {1'b1, byte_q[BYTE_W-1:1]};
        end else if (st == ST_CELL) begin
            tmr <= tmr + DIV_W'(1);
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_o      <= 1'b0;
            busy_o     <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            led_o  <= (st == ST_CELL) && !cur_level && carrier_on;
            busy_o <= (st != ST_IDLE);
            if (st == ST_IDLE && start_ok)
                underrun_o <= 1'b0;
            else if (byte_end && fifo_empty && !defer_en)
                underrun_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ir_mod_tx.sv
module ir_mod_tx import ir_tx_pkg::*; #(
    parameter int FIFO_DEPTH = 16,
    parameter int DEFER_LVL  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [7:0] div_lo,
    input  logic [7:0] div_hi,
    input  logic       carrier_hi_range,
    input  logic [4:0] carrier_code,
    input  logic [1:0] pulse_sel,
    input  logic [2:0] duty_sel,
    input  logic       rle_mode,
    input  logic       defer_en,
    output logic       led_o,
    output logic       busy_o,
    output logic       fifo_empty_o,
    output logic       fifo_full_o,
    output logic       underrun_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int DIV_W = 2 * BYTE_W;

    logic [CNT_W-1:0]  fifo_count;
    logic [BYTE_W-1:0] fifo_head;
    logic              fifo_pop, car_restart, carrier_on, cur_level;
    tx_state_e         st;

    ir_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W), .CW(CNT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (wr_en),
        .wr_data (wr_data),
        .pop     (fifo_pop),
        .head    (fifo_head),
        .count   (fifo_count),
        .empty   (fifo_empty_o),
        .full    (fifo_full_o)
    );

    ir_carrier_gen u_car (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (car_restart),
        .hi_range   (carrier_hi_range),
        .code       (carrier_code),
        .pulse_sel  (pulse_sel),
        .duty_sel   (duty_sel),
        .carrier_on (carrier_on)
    );

    ir_tx_ctrl #(.CW(CNT_W), .DEFER_LVL(DEFER_LVL), .DIV_W(DIV_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .defer_en    (defer_en),
        .rle_mode    (rle_mode),
        .cell_div    ({div_hi, div_lo}),
        .fifo_count  (fifo_count),
        .fifo_empty  (fifo_empty_o),
        .fifo_head   (fifo_head),
        .carrier_on  (carrier_on),
        .fifo_pop    (fifo_pop),
        .car_restart (car_restart),
        .led_o       (led_o),
        .busy_o      (busy_o),
        .underrun_o  (underrun_o),
        .state_o     (st),
        .cur_level_o (cur_level)
    );
endmodule

// File: rtl/ir_mod_tx_chk.sv
module ir_mod_tx_chk import ir_tx_pkg::*; #(
    parameter int CW        = 5,
    parameter int DEFER_LVL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          defer_en,
    input logic          led_o,
    input logic          busy_o,
    input logic          empty_o,
    input logic          full_o,
    input logic          underrun_o,
    input logic          fifo_pop,
    input logic [CW-1:0] fifo_count,
    input tx_state_e     st,
    input logic          cur_level
);
    AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !led_o);                                             // R10
    AST_LOAD_THEN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> (st == ST_CELL));                            // R10
    AST_MARK_CELL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CELL && cur_level) |=> !led_o);                        // R3
    AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));                                           // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !fifo_pop) |=> full_o);                               // R8
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !empty_o);                                          // R8
    AST_DEFER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && defer_en && fifo_count < CW'(DEFER_LVL)) |=> (st == ST_IDLE)); // R7
    AST_UNDERRUN_NODEFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> !$past(defer_en));                         // R9
endmodule

bind ir_mod_tx ir_mod_tx_chk #(.CW(CNT_W), .DEFER_LVL(DEFER_LVL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .defer_en   (defer_en),
    .led_o      (led_o),
    .busy_o     (busy_o),
    .empty_o    (fifo_empty_o),
    .full_o     (fifo_full_o),
    .underrun_o (underrun_o),
    .fifo_pop   (fifo_pop),
    .fifo_count (fifo_count),
    .st         (st),
    .cur_level  (cur_level)
);

// File: tb/sim_ir_mod_tx.sv
module sim_ir_mod_tx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] div_lo = '0, div_hi = '0;
    logic       rng = 1'b0;
    logic [4:0] code = '0;
    logic [1:0] psel = '0;
    logic [2:0] dsel = '0;
    logic       rle = 1'b0, defer = 1'b0;
    logic       led_o, busy_o, fifo_empty_o, fifo_full_o, underrun_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    bit full_seen;
    logic [7:0] frame [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_mod_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .div_lo(div_lo), .div_hi(div_hi), .carrier_hi_range(rng),
        .carrier_code(code), .pulse_sel(psel), .duty_sel(dsel),
        .rle_mode(rle), .defer_en(defer), .led_o(led_o), .busy_o(busy_o),
        .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o), .underrun_o(underrun_o)
    );

    task automatic check(bit ok, string req, string what, int got, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Model of R3/R4/R5: expected LED at offset k of a cell with a given level.
    function automatic int exp_led(logic lvl, int k);
        int per, eighths, hi_t, npulse;
        per     = rng ? 8 + int'(code) : 32 + 4 * int'(code);
        eighths = (dsel > 3) ? 4 : int'(dsel) + 1;
        hi_t    = (per * eighths) / 8;
        npulse  = int'(psel) + 1;
        return (!lvl && (k / per) < npulse && (k % per) < hi_t) ? 1 : 0;
    endfunction

    function automatic int div_val();
        return int'({div_hi, div_lo});
    endfunction

    // Writes frame[wr_from..nwr-1], then checks the LED stream for frame[0..nexp-1].
    task automatic frame_run(string req, int wr_from, int nwr, int nexp);
        int bad = 0, first_got = 0, first_exp = 0;
        fork
            begin
                for (int i = wr_from; i < nwr; i++) begin
                    @(negedge clk);
                    wr_en = 1'b1;
                    wr_data = frame[i];
                end
                @(negedge clk);
                wr_en = 1'b0;
                full_seen = fifo_full_o;
            end
            begin
                int wd = 0;
                @(negedge clk);
                while (!busy_o && wd < 5000) begin
                    @(negedge clk);
                    wd++;
                end
                if (led_o !== 1'b0) begin bad++; first_got = 1; first_exp = 0; end
                for (int b = 0; b < nexp; b++) begin
                    int ncell;
                    logic [7:0] v;
                    v = frame[b];
                    ncell = rle ? int'(v[6:0]) + 1 : 8;
                    for (int c = 0; c < ncell; c++) begin
                        logic lvl;
                        lvl = rle ? v[7] : v[c];
                        for (int k = 0; k <= div_val(); k++) begin
                            int e;
                            @(negedge clk);
                            e = exp_led(lvl, k);
                            if (led_o !== e[0] || busy_o !== 1'b1) begin
                                if (bad == 0) begin first_got = int'(led_o); first_exp = e; end
                                bad++;
                            end
                        end
                    end
                end
                @(negedge clk);
                if (busy_o !== 1'b0) begin
                    if (bad == 0) begin first_got = 1; first_exp = 0; end
                    bad++;
                end
            end
        join
        check(bad == 0, req, "LED/busy stream (first mismatch led)", first_got, first_exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R10 watchdog expired: got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10/R8: reset state
        check(led_o == 0 && busy_o == 0, "R10", "reset led|busy", int'(led_o | busy_o), 0);
        check(underrun_o == 0, "R10", "reset underrun", int'(underrun_o), 0);
        check(fifo_empty_o == 1 && fifo_full_o == 0, "R8", "reset empty flag", int'(fifo_empty_o), 1);

        // R1 R2 R3 R4 R5: plain bytes, low range, no deferral
        {div_hi, div_lo} = 16'd40; rng = 0; code = 5'd2; psel = 2'd1; dsel = 3'd1;
        rle = 0; defer = 0;
        frame[0] = 8'hA5; frame[1] = 8'h3C;
        frame_run("R1", 0, 2, 2);
        check(underrun_o == 1, "R9", "underrun after dry end", int'(underrun_o), 1);

        // R4 R5: high range, clamped duty, four pulses; R2 with a high-byte divisor
        {div_hi, div_lo} = 16'd300; rng = 1; code = 5'd31; psel = 2'd3; dsel = 3'd6;
        frame[0] = 8'h0F;
        frame_run("R5", 0, 1, 1);

        // R6: run-length bytes
        {div_hi, div_lo} = 16'd12; rng = 1; code = 5'd0; psel = 2'd1; dsel = 3'd2;
        rle = 1;
        frame[0] = 8'h02; frame[1] = 8'h81; frame[2] = 8'h00; frame[3] = 8'h03;
        frame_run("R6", 0, 4, 4);

        // R7: deferral holds start below the level
        rle = 0; defer = 1; {div_hi, div_lo} = 16'd5; rng = 0; code = 5'd0; dsel = 3'd0; psel = 2'd0;
        frame[0] = 8'h55; frame[1] = 8'hF0; frame[2] = 8'h0F; frame[3] = 8'h00;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = frame[i];
        end
        @(negedge clk); wr_en = 1'b0;
        repeat (60) @(negedge clk);
        check(busy_o == 0 && led_o == 0, "R7", "busy while below deferral level", int'(busy_o), 0);
        frame_run("R7", 3, 4, 4);
        check(underrun_o == 0, "R9", "underrun with deferral on", int'(underrun_o), 0);

        // R8: overflow drops writes; 19 written, one popped, 17 sent
        {div_hi, div_lo} = 16'd9;
        for (int i = 0; i < 19; i++) frame[i] = 8'(i * 37 + 5);
        frame_run("R8", 0, 19, 17);
        check(full_seen == 1, "R8", "full flag after overflow writes", int'(full_seen), 1);
        check(fifo_empty_o == 1, "R8", "queue empty after drain", int'(fifo_empty_o), 1);

        // Random configurations (R1 R3 R6 R9)
        for (int t = 0; t < 6; t++) begin
            int nb;
            nb = 4 + int'($urandom % 7);
            rle = 1'($urandom);
            defer = 1'($urandom);
            {div_hi, div_lo} = 16'(3 + $urandom % 18);
            rng = 1'($urandom);
            code = 5'($urandom);
            psel = 2'($urandom);
            dsel = 3'($urandom);
            for (int i = 0; i < nb; i++)
                frame[i] = rle ? {1'($urandom), 3'b000, 4'($urandom)} : 8'($urandom);
            frame_run(rle ? "R6" : "R1", 0, nb, nb);
            check(underrun_o == !defer, "R9", "underrun after random frame", int'(underrun_o), int'(!defer));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule